// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block manages the power-down state of a small microcontroller core. When the instruction decoder asks for sleep, the controller turns off the core oscillator enable, stalls the core, and pulses a clear to the watchdog counter. The watchdog counter keeps running while the core sleeps. Three events end sleep. An asserted external reset pin causes a full reset. A watchdog time-out causes a wake-up. A peripheral interrupt flag whose own enable bit is set also causes a wake-up, whatever the state of the global interrupt enable.

After a wake-up the controller turns the oscillator back on and holds the core stalled for a programmable settle time. It then releases the core with a one-cycle resume pulse, and the core carries on with the instruction it prefetched after sleep. If the wake came from an interrupt and the global enable is set, a branch-to-vector pulse follows one cycle after resume. Two status bits let software tell a power-up from a wake out of sleep or a watchdog time-out: a power-down bit, which sleep clears, and a time-out bit, which a watchdog expiry clears. The interrupt flags arrive from other clock domains and pass through a two-flop synchronizer.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After power-on reset (rst_n low), pd_bit=1, to_bit=1, osc_en=1, core_stall=0, reset_req=0, resume=0 and vector_req=0.
- R2: A sleep_req cycle while running, with no armed interrupt, no ext_rst and no wdt_timeout, pulses wdt_clr in that same cycle. From the next cycle osc_en=0, core_stall=1, pd_bit=0 and to_bit=1.
- R3: wdt_timeout without ext_rst clears to_bit from the next cycle. During sleep it also wakes the core, so osc_en=1 from the next cycle, and it never leads to vector_req.
- R4: wdt_timeout while not asleep (and without ext_rst) makes reset_req high for exactly the next cycle, and the core stays unstalled.
- R5: ext_rst (active high, synchronous) makes reset_req high in the next cycle and returns the controller to the running state (osc_en=1, core_stall=0) without changing pd_bit or to_bit. This holds during sleep as well.
- R6: An interrupt flag bit i with irq_en[i]=1 wakes the core from sleep: osc_en rises within 3 cycles of the flag rising, whether gie is 0 or 1. A flag whose enable bit is 0 does not wake it.
- R7: A sleep_req that arrives while a synchronized enabled flag is already pending is cancelled: osc_en stays 1, core_stall stays 0, and pd_bit and to_bit do not change.
- R8: After osc_en returns from a wake, core_stall stays high for exactly osc_settle+1 cycles. resume is then high for one cycle, in the first cycle with core_stall=0.
- R9: vector_req is high for one cycle, one cycle after resume, if and only if the wake came from an interrupt and gie=1 in the resume-producing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req | input | 1 | Sleep request from the instruction decoder |
| ext_rst | input | 1 | External reset pin, synchronized, active high |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| irq_flags | input | N_IRQ | Interrupt flags from peripherals, asynchronous |
| irq_en | input | N_IRQ | Per-flag wake/interrupt enable bits |
| gie | input | 1 | Global interrupt enable |
| osc_settle | input | SETTLE_W | Settle wait after oscillator restart, in cycles minus one |
| osc_en | output | 1 | Core oscillator enable |
| core_stall | output | 1 | Holds the core pipeline |
| wdt_clr | output | 1 | Clears the watchdog counter on sleep entry |
| resume | output | 1 | Core continues at the prefetched next instruction |
| vector_req | output | 1 | Core branches to the interrupt vector |
| reset_req | output | 1 | Full device reset request |
| pd_bit | output | 1 | Power-down status bit |
| to_bit | output | 1 | Time-out status bit |

## Verification
A controller stuck in the wrong state shows up at once as a mismatch between osc_en and core_stall. A wrong entry also shows as a missing wdt_clr, and both appear within one cycle of the request. A miscounting settle timer changes the number of stalled cycles with the oscillator on, and a lost wake cause shows up as vector_req present or missing one cycle after resume. A status register that is set or cleared at the wrong time is seen on pd_bit or to_bit in the cycle after sleep entry or a watchdog expiry.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2
  } pwr_state_e;

  // Number of stalled cycles with the oscillator running, for a settle code.
  function automatic int unsigned stall_len(input int unsigned settle_code);
    return settle_code + 1;
  endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] flags_async,
  input  logic [N_IRQ-1:0] en,
  output logic             armed_o
);
  logic [N_IRQ-1:0] meta_q;
  logic [N_IRQ-1:0] sync_q;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= flags_async[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign armed_o = |(sync_q & en);
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  input  logic                run,
  output logic                expired_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_status_bits.sv
module pwr_status_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_entry,
  input  logic wdt_event,
  output logic pd_o,
  output logic to_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_o <= 1'b1;
      to_o <= 1'b1;
    end else if (wdt_event) begin
      to_o <= 1'b0;
    end else if (sleep_entry) begin
      pd_o <= 1'b0;
      to_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int N_IRQ    = 8,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic                ext_rst,
  input  logic                wdt_timeout,
  input  logic [N_IRQ-1:0]    irq_flags,
  input  logic [N_IRQ-1:0]    irq_en,
  input  logic                gie,
  input  logic [SETTLE_W-1:0] osc_settle,
  output logic                osc_en,
  output logic                core_stall,
  output logic                wdt_clr,
  output logic                resume,
  output logic                vector_req,
  output logic                reset_req,
  output logic                pd_bit,
  output logic                to_bit
);
  pwr_state_e state_q, state_d;
  logic armed, settle_expired;
  logic in_run, in_sleep, in_settle;
  logic wake_irq_q, resume_q, vec_arm_q, vector_q, reset_req_q;

  // Named internal events
  logic ev_enter_sleep, ev_cancel, ev_wdt_wake, ev_wdt_reset;
  logic ev_irq_wake, ev_ext_reset, ev_release, ev_wdt_event;

  pwr_wake_sync #(.N_IRQ(N_IRQ)) u_sync (
    .clk(clk), .rst_n(rst_n), .flags_async(irq_flags), .en(irq_en), .armed_o(armed)
  );

  assign in_run    = (state_q == ST_RUN);
  assign in_sleep  = (state_q == ST_SLEEP);
  assign in_settle = (state_q == ST_SETTLE);

  assign ev_ext_reset   = ext_rst;
  assign ev_wdt_event   = wdt_timeout & ~ext_rst;
  assign ev_wdt_wake    = in_sleep & ev_wdt_event;
  assign ev_wdt_reset   = ~in_sleep & ev_wdt_event;
  assign ev_irq_wake    = in_sleep & armed & ~ext_rst & ~wdt_timeout;
  assign ev_cancel      = in_run & sleep_req & armed & ~ext_rst & ~wdt_timeout;
  assign ev_enter_sleep = in_run & sleep_req & ~armed & ~ext_rst & ~wdt_timeout;
  assign ev_release     = in_settle & settle_expired & ~ext_rst & ~wdt_timeout;

  pwr_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(ev_wdt_wake | ev_irq_wake), .load_val(osc_settle),
    .run(in_settle), .expired_o(settle_expired)
  );

  pwr_status_bits u_status (
    .clk(clk), .rst_n(rst_n),
    .sleep_entry(ev_enter_sleep), .wdt_event(ev_wdt_event),
    .pd_o(pd_bit), .to_o(to_bit)
  );

  always_comb begin
    state_d = state_q;
    if (ev_ext_reset || ev_wdt_reset) state_d = ST_RUN;
    else if (ev_enter_sleep)          state_d = ST_SLEEP;
    else if (ev_wdt_wake || ev_irq_wake) state_d = ST_SETTLE;
    else if (ev_release)              state_d = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      wake_irq_q  <= 1'b0;
      resume_q    <= 1'b0;
      vec_arm_q   <= 1'b0;
      vector_q    <= 1'b0;
      reset_req_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      if (ev_irq_wake)      wake_irq_q <= 1'b1;
      else if (ev_wdt_wake) wake_irq_q <= 1'b0;
      resume_q    <= ev_release;
      vec_arm_q   <= ev_release & wake_irq_q & gie;
      vector_q    <= vec_arm_q & ~ext_rst;
      reset_req_q <= ev_ext_reset | ev_wdt_reset;
    end
  end

  assign osc_en     = ~in_sleep;
  assign core_stall = ~in_run;
  assign wdt_clr    = ev_enter_sleep;
  assign resume     = resume_q;
  assign vector_req = vector_q;
  assign reset_req  = reset_req_q;
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_rst,
  input logic wdt_timeout,
  input logic osc_en,
  input logic core_stall,
  input logic resume,
  input logic vector_req,
  input logic reset_req,
  input logic pd_bit,
  input logic to_bit,
  input logic ev_enter_sleep,
  input logic ev_cancel,
  input logic ev_wdt_wake
);
  // Oscillator off only while the core is held
  assert_osc_off_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> core_stall);

  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter_sleep |=> (!osc_en && !pd_bit && to_bit));

  assert_wdt_clears_to_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_timeout && !ext_rst) |=> !to_bit);

  assert_wdt_wake_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt_wake |=> osc_en);

  assert_ext_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> (reset_req && osc_en && !core_stall && $stable(pd_bit) && $stable(to_bit)));

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cancel |=> (osc_en && !core_stall && $stable(pd_bit)));

  assert_resume_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (!core_stall && osc_en));

  assert_resume_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  assert_vector_after_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vector_req |-> $past(resume));
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .wdt_timeout(wdt_timeout),
  .osc_en(osc_en), .core_stall(core_stall), .resume(resume),
  .vector_req(vector_req), .reset_req(reset_req), .pd_bit(pd_bit), .to_bit(to_bit),
  .ev_enter_sleep(ev_enter_sleep), .ev_cancel(ev_cancel), .ev_wdt_wake(ev_wdt_wake)
);

// File: tb/pwr_sleep_ctrl_tb.sv
module pwr_sleep_ctrl_tb;
  localparam int N_IRQ = 8;
  localparam int SETTLE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, ext_rst = 1'b0, wdt_timeout = 1'b0, gie = 1'b0;
  logic [N_IRQ-1:0] irq_flags = '0, irq_en = '0;
  logic [SETTLE_W-1:0] osc_settle = '0;
  logic osc_en, core_stall, wdt_clr, resume, vector_req, reset_req, pd_bit, to_bit;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pwr_sleep_ctrl #(.N_IRQ(N_IRQ), .SETTLE_W(SETTLE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ext_rst(ext_rst),
    .wdt_timeout(wdt_timeout), .irq_flags(irq_flags), .irq_en(irq_en), .gie(gie),
    .osc_settle(osc_settle), .osc_en(osc_en), .core_stall(core_stall), .wdt_clr(wdt_clr),
    .resume(resume), .vector_req(vector_req), .reset_req(reset_req),
    .pd_bit(pd_bit), .to_bit(to_bit)
  );

  function automatic int exp_stall(input int code);
    return code + 1;
  endfunction

  function automatic bit exp_vector(input bit by_irq, input bit g);
    return by_irq && g;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic enter_sleep();
    sleep_req = 1'b1;
    #0.1;
    chk("R2 wdt_clr", wdt_clr, 1);
    tick();
    sleep_req = 1'b0;
    chk("R2 osc_en", osc_en, 0);
    chk("R2 core_stall", core_stall, 1);
    chk("R2 pd_bit", pd_bit, 0);
    chk("R2 to_bit", to_bit, 1);
  endtask

  task automatic wake_cycle(input bit by_irq, input bit g, input int code, input int idx);
    int n;
    int stalled;
    osc_settle = SETTLE_W'(code);
    gie = g;
    enter_sleep();
    if (by_irq) begin
      irq_flags[idx] = 1'b1;
      n = 0;
      while (!osc_en && n < 8) begin
        tick();
        n++;
      end
      chk("R6 wake latency <=3", (n <= 3) ? 1 : 0, 1);
      irq_flags[idx] = 1'b0;
      chk("R3 to_bit kept on irq wake", to_bit, 1);
    end else begin
      wdt_timeout = 1'b1;
      tick();
      wdt_timeout = 1'b0;
      chk("R3 osc_en after wdt wake", osc_en, 1);
      chk("R3 to_bit cleared", to_bit, 0);
    end
    stalled = 0;
    while (osc_en && core_stall && stalled < 400) begin
      stalled++;
      tick();
    end
    chk("R8 stall length", stalled, exp_stall(code));
    chk("R8 resume pulse", resume, 1);
    chk("R8 stall released", core_stall, 0);
    tick();
    chk("R9 vector_req", vector_req, exp_vector(by_irq, g));
    chk("R8 resume single", resume, 0);
    tick();
    chk("R9 vector single", vector_req, 0);
    repeat (3) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit by_irq, g;
    int code, idx, pd_prev, to_prev;
    void'($urandom(32'h5EED1234));
    repeat (3) tick();
    // R1 reset state
    chk("R1 pd_bit", pd_bit, 1);
    chk("R1 to_bit", to_bit, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 core_stall", core_stall, 0);
    chk("R1 reset_req", reset_req, 0);
    chk("R1 resume", resume, 0);
    rst_n = 1'b1;
    irq_en = '1;
    tick();

    // Directed: interrupt wake with gie clear, then set; watchdog wake; zero settle
    wake_cycle(1'b1, 1'b0, 2, 0);
    wake_cycle(1'b1, 1'b1, 0, N_IRQ - 1);
    wake_cycle(1'b0, 1'b1, 5, 0);

    // R6: disabled flag does not wake
    irq_en = 8'hFE;
    enter_sleep();
    irq_flags[0] = 1'b1;
    repeat (6) tick();
    chk("R6 masked flag no wake", osc_en, 0);
    irq_flags[0] = 1'b0;
    irq_en = '1;
    // R5: external reset during sleep
    pd_prev = pd_bit; to_prev = to_bit;
    ext_rst = 1'b1;
    tick();
    ext_rst = 1'b0;
    chk("R5 reset_req", reset_req, 1);
    chk("R5 osc_en", osc_en, 1);
    chk("R5 core_stall", core_stall, 0);
    chk("R5 pd_bit unchanged", pd_bit, pd_prev);
    chk("R5 to_bit unchanged", to_bit, to_prev);
    tick();
    chk("R5 reset_req single", reset_req, 0);

    // R4: watchdog expiry while running
    wdt_timeout = 1'b1;
    tick();
    wdt_timeout = 1'b0;
    chk("R4 reset_req", reset_req, 1);
    chk("R4 running", core_stall, 0);
    chk("R3 to_bit cleared running", to_bit, 0);
    tick();
    chk("R4 reset_req single", reset_req, 0);

    // R7: pending wake cancels sleep
    irq_flags[3] = 1'b1;
    repeat (3) tick();
    pd_prev = pd_bit; to_prev = to_bit;
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    chk("R7 osc_en kept", osc_en, 1);
    chk("R7 no stall", core_stall, 0);
    chk("R7 pd_bit unchanged", pd_bit, pd_prev);
    chk("R7 to_bit unchanged", to_bit, to_prev);
    irq_flags[3] = 1'b0;
    repeat (3) tick();

    // Random rounds
    for (int k = 0; k < 20; k++) begin
      by_irq = 1'($urandom_range(0, 1));
      g = 1'($urandom_range(0, 1));
      code = $urandom_range(0, 9);
      idx = $urandom_range(0, N_IRQ - 1);
      wake_cycle(by_irq, g, code, idx);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule